// File: doc/BRIEF.md
# Banked UART Register Decoder

This block is the host-side register file of an enhanced 16550-style UART. Sixteen addresses are shared by several overlapping banks. The register an access reaches depends on three things:

- the value currently held in the line-control register;
- an enhanced-function enable bit (bit 4 of the enhanced-feature register);
- a trigger-access bit (bit 6 of modem-control).

Software moves between banks by rewriting line-control. Writing the key value 0xBF opens the enhanced bank. Setting bit 7 of line-control exposes autobaud status. Setting both gate bits reveals the trigger-control and trigger-level registers.

Reads are combinational from the address. A write takes effect at the rising clock edge on which the write strobe is high. Serial shifting, FIFOs and baud generation are outside this block. Their state arrives only as read-only status inputs, which are passed through when the current bank shows them.

Top module: `uart_bank_regs`

## Requirements
- R1: After reset the following registers hold these values: line-control 0x00, interrupt-enable 0x00, enhanced-feature 0x00, modem-control 0x00, supplementary-control 0x00, trigger-control 0x00, trigger-level 0x00, scratch 0x00, and mode 0x07.
- R2: Address 3 always reads and writes the full 8-bit line-control register.
- R3: At address 2, the behaviour depends on line-control:
  - line-control equal to 0xBF: the 8-bit enhanced-feature register is read and written;
  - otherwise: writes have no effect;
  - reads return iir_st when line-control bit 7 is 0, and 0x00 when it is 1.
- R4: At address 5, reads return lsr_st when line-control bit 7 is 0, otherwise 0x00. Bit 0 of this value means receive data available, and bit 6 means transmitter and holding register both empty.
- R5: At address 14, reads return uasr_st when line-control bit 7 is 1, otherwise 0x00. Writes have no effect.
- R6: Address 1 is interrupt-enable while line-control bit 7 is 0.
  - Bits 3:0 are always writable.
  - Bits 7:4 change only while enhanced-feature bit 4 is 1.
  - With line-control bit 7 set, reads return 0x00 and writes have no effect.
- R7: Address 4 is modem-control while line-control bit 7 is 0.
  - Bits 4:0 are always writable.
  - Bits 7:5 change only while enhanced-feature bit 4 is 1.
  - With line-control bit 7 set, reads return 0x00 and writes have no effect.
- R8: When enhanced-feature bit 4, modem-control bit 6 and the complement of line-control bit 7 are all 1, address 6 is the 8-bit trigger-control register and address 7 is the 8-bit trigger-level register, both read/write.
- R9: When the trigger gate of R8 is closed and line-control bit 7 is 0:
  - address 6 reads msr_st and ignores writes;
  - address 7 is an 8-bit read/write scratch register.
  - With line-control bit 7 set, both addresses read 0x00 and ignore writes.
- R10: The following addresses behave the same in every bank:
  - address 8 is the mode register, which stores and returns only bits 5:0 (mask 0x3F);
  - address 9 is the 8-bit supplementary-control register;
  - address 10 reads ssr_st.
- R11: Addresses 0, 11, 12, 13 and 15 read 0x00, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes take effect on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe |
| rdata | output | 8 | Read data for addr in the current bank |
| iir_st | input | 8 | Interrupt-identification status |
| lsr_st | input | 8 | Line status (bit 0 receive data available, bit 6 transmitter empty) |
| msr_st | input | 8 | Modem status |
| ssr_st | input | 8 | Supplementary status |
| uasr_st | input | 8 | Autobaud status |

## Verification
A wrong bank decision or a corrupted gate bit shows up at rdata combinationally. It is therefore visible on the very next read of any shadowed address, where the wrong register or status input appears. A write that leaks into a hidden register does not show up when it happens. It becomes visible only after software reopens the bank holding that register, so the bench re-reads all sixteen addresses after every single write. This covers several line-control values and every combination of the two gate bits.

// File: rtl/uart_bank_pkg.sv
// Package: widths, address map, bank key and shared types for the banked
// UART register decoder. Assumes an 8-bit data path and a 4-bit address.
package uart_bank_pkg;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 4;

    localparam logic [DATA_W-1:0] ENH_KEY   = 8'hBF;
    localparam logic [DATA_W-1:0] MODE_MASK = 8'h3F;
    localparam logic [DATA_W-1:0] MODE_RST  = 8'h07;

    localparam int BANK_BIT     = 7;
    localparam int GATE_EFR_BIT = 4;
    localparam int GATE_MCR_BIT = 6;
    localparam int IER_LOCK_LSB = 4;
    localparam int MCR_LOCK_LSB = 5;

    localparam logic [ADDR_W-1:0] A_IER  = 4'd1;
    localparam logic [ADDR_W-1:0] A_ISR  = 4'd2;
    localparam logic [ADDR_W-1:0] A_LCR  = 4'd3;
    localparam logic [ADDR_W-1:0] A_MCR  = 4'd4;
    localparam logic [ADDR_W-1:0] A_LSR  = 4'd5;
    localparam logic [ADDR_W-1:0] A_TCR  = 4'd6;
    localparam logic [ADDR_W-1:0] A_TLR  = 4'd7;
    localparam logic [ADDR_W-1:0] A_MODE = 4'd8;
    localparam logic [ADDR_W-1:0] A_SUPC = 4'd9;
    localparam logic [ADDR_W-1:0] A_SUPS = 4'd10;
    localparam logic [ADDR_W-1:0] A_ABD  = 4'd14;

    // Which bank the shared addresses currently expose.
    typedef struct packed {
        logic lo;    // line-control bit 7 clear
        logic enh;   // line-control equals the enhanced key
        logic trig;  // trigger registers visible
    } view_t;

    // All writable registers of the block.
    typedef struct packed {
        logic [DATA_W-1:0] lcr;
        logic [DATA_W-1:0] ier;
        logic [DATA_W-1:0] efr;
        logic [DATA_W-1:0] mcr;
        logic [DATA_W-1:0] mode;
        logic [DATA_W-1:0] supc;
        logic [DATA_W-1:0] tcr;
        logic [DATA_W-1:0] tlr;
        logic [DATA_W-1:0] spr;
    } regs_t;
endpackage

// File: rtl/uart_bank_select.sv
// Bank selector: turns line-control and the two gate bits into a view of
// which bank the shared addresses reach. Purely combinational; assumes the
// register inputs come straight from flops.
module uart_bank_select
    import uart_bank_pkg::*;
(
    input  logic [DATA_W-1:0] lcr,
    input  logic              efr_gate,
    input  logic              mcr_gate,
    output view_t             view
);
    // Derive the bank flags from the current control values.
    always_comb begin
        view.lo   = !lcr[BANK_BIT];
        view.enh  = (lcr == ENH_KEY);
        view.trig = !lcr[BANK_BIT] && efr_gate && mcr_gate;
    end
endmodule

// File: rtl/uart_reg_store.sv
// Register storage: holds every writable register and applies a write only
// when the addressed register is visible in the current bank. Bits above the
// lock boundary of interrupt-enable and modem-control need the enhanced gate.
// Assumes synchronous active-low reset.
module uart_reg_store
    import uart_bank_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wr_en,
    input  view_t             view,
    output regs_t             regs
);
    localparam regs_t RST_VAL = '{lcr: '0, ier: '0, efr: '0, mcr: '0,
                                  mode: MODE_RST, supc: '0, tcr: '0,
                                  tlr: '0, spr: '0};

    // Keep low bits new, upper bits old unless the enhanced gate is open.
    function automatic logic [DATA_W-1:0] lock_merge(
        input logic [DATA_W-1:0] old_v,
        input logic [DATA_W-1:0] new_v,
        input int                lsb,
        input logic              unlock
    );
        logic [DATA_W-1:0] res;
        for (int i = 0; i < DATA_W; i++)
            res[i] = (i < lsb || unlock) ? new_v[i] : old_v[i];
        return res;
    endfunction

    logic unlock;
    assign unlock = regs.efr[GATE_EFR_BIT];

    // Reset or update the addressed register when it is visible.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs <= RST_VAL;
        end else if (wr_en) begin
            case (addr)
                A_LCR:  regs.lcr <= wdata;
                A_ISR:  if (view.enh) regs.efr <= wdata;
                A_IER:  if (view.lo)
                            regs.ier <= lock_merge(regs.ier, wdata, IER_LOCK_LSB, unlock);
                A_MCR:  if (view.lo)
                            regs.mcr <= lock_merge(regs.mcr, wdata, MCR_LOCK_LSB, unlock);
                A_TCR:  if (view.trig) regs.tcr <= wdata;
                A_TLR:  if (view.trig) regs.tlr <= wdata;
                        else if (view.lo) regs.spr <= wdata;
                A_MODE: regs.mode <= wdata & MODE_MASK;
                A_SUPC: regs.supc <= wdata;
                default: ;
            endcase
        end
    end

    // R2
    lcr_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && addr == A_LCR |=> regs.lcr == $past(wdata));
    // R3
    efr_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && addr == A_ISR && !view.enh |=> $stable(regs.efr));
    // R6
    ier_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && addr == A_IER && !unlock |=> regs.ier[7:4] == $past(regs.ier[7:4]));
    // R8
    trig_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && addr == A_TCR && !view.trig |=> $stable(regs.tcr));
    // R10
    mode_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (regs.mode & ~MODE_MASK) == '0);
endmodule

// File: rtl/uart_read_mux.sv
// Read multiplexer: returns the register or status input that the current
// bank places at the address; invisible or empty slots return zero.
module uart_read_mux
    import uart_bank_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  view_t             view,
    input  regs_t             regs,
    input  logic [DATA_W-1:0] iir_st,
    input  logic [DATA_W-1:0] lsr_st,
    input  logic [DATA_W-1:0] msr_st,
    input  logic [DATA_W-1:0] ssr_st,
    input  logic [DATA_W-1:0] uasr_st,
    output logic [DATA_W-1:0] rdata
);
    // Select the read value for the addressed slot in the active bank.
    always_comb begin
        rdata = '0;
        case (addr)
            A_IER:  if (view.lo) rdata = regs.ier;
            A_ISR:  if (view.enh) rdata = regs.efr;
                    else if (view.lo) rdata = iir_st;
            A_LCR:  rdata = regs.lcr;
            A_MCR:  if (view.lo) rdata = regs.mcr;
            A_LSR:  if (view.lo) rdata = lsr_st;
            A_TCR:  if (view.trig) rdata = regs.tcr;
                    else if (view.lo) rdata = msr_st;
            A_TLR:  if (view.trig) rdata = regs.tlr;
                    else if (view.lo) rdata = regs.spr;
            A_MODE: rdata = regs.mode & MODE_MASK;
            A_SUPC: rdata = regs.supc;
            A_SUPS: rdata = ssr_st;
            A_ABD:  if (!view.lo) rdata = uasr_st;
            default: ;
        endcase
    end

    // R4
    lsr_view_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr == A_LSR && view.lo |-> rdata == lsr_st);
    // R9
    msr_view_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr == A_TCR && view.lo && !view.trig |-> rdata == msr_st);
    // R11
    gap_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr == '0 |-> rdata == '0);
endmodule

// File: rtl/uart_bank_regs.sv
// Top of the banked UART register decoder: wires the bank selector, the
// register storage and the read multiplexer. Reads are combinational; a
// write lands on the rising edge with wr_en high. Synchronous active-low reset.
module uart_bank_regs
    import uart_bank_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wr_en,
    output logic [DATA_W-1:0] rdata,
    input  logic [DATA_W-1:0] iir_st,
    input  logic [DATA_W-1:0] lsr_st,
    input  logic [DATA_W-1:0] msr_st,
    input  logic [DATA_W-1:0] ssr_st,
    input  logic [DATA_W-1:0] uasr_st
);
    view_t view;
    regs_t regs;

    uart_bank_select u_sel (
        .lcr      (regs.lcr),
        .efr_gate (regs.efr[GATE_EFR_BIT]),
        .mcr_gate (regs.mcr[GATE_MCR_BIT]),
        .view     (view)
    );

    uart_reg_store u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .addr  (addr),
        .wdata (wdata),
        .wr_en (wr_en),
        .view  (view),
        .regs  (regs)
    );

    uart_read_mux u_mux (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (addr),
        .view    (view),
        .regs    (regs),
        .iir_st  (iir_st),
        .lsr_st  (lsr_st),
        .msr_st  (msr_st),
        .ssr_st  (ssr_st),
        .uasr_st (uasr_st),
        .rdata   (rdata)
    );

    // R3
    iir_view_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr == A_ISR && view.lo |-> rdata == iir_st);
    // R5
    abd_view_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr == A_ABD && regs.lcr[BANK_BIT] |-> rdata == uasr_st);
endmodule

// File: tb/uart_bank_regs_test.sv
`timescale 1ns/1ps
module uart_bank_regs_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] addr = '0;
    logic [7:0] wdata = '0;
    logic       wr_en = 1'b0;
    logic [7:0] rdata;
    logic [7:0] iir_st = 8'hC1, lsr_st = 8'h41, msr_st = 8'hB0, ssr_st = 8'h05, uasr_st = 8'h2A;

    int  total = 0;
    int  bad   = 0;
    bit  done  = 0;

    // bench model of the registers, built from the requirements
    logic [7:0] m_lcr, m_ier, m_efr, m_mcr, m_mode, m_supc, m_tcr, m_tlr, m_spr;

    always #2.5 clk = ~clk;

    uart_bank_regs uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
        .rdata(rdata), .iir_st(iir_st), .lsr_st(lsr_st), .msr_st(msr_st),
        .ssr_st(ssr_st), .uasr_st(uasr_st)
    );

    function automatic bit m_trig();
        return !m_lcr[7] && m_efr[4] && m_mcr[6];
    endfunction

    function automatic logic [7:0] m_read(input logic [3:0] a);
        logic lo = !m_lcr[7];
        case (a)
            4'd1:  return lo ? m_ier : 8'h00;
            4'd2:  return (m_lcr == 8'hBF) ? m_efr : (lo ? iir_st : 8'h00);
            4'd3:  return m_lcr;
            4'd4:  return lo ? m_mcr : 8'h00;
            4'd5:  return lo ? lsr_st : 8'h00;
            4'd6:  return m_trig() ? m_tcr : (lo ? msr_st : 8'h00);
            4'd7:  return m_trig() ? m_tlr : (lo ? m_spr : 8'h00);
            4'd8:  return m_mode;
            4'd9:  return m_supc;
            4'd10: return ssr_st;
            4'd14: return lo ? 8'h00 : uasr_st;
            default: return 8'h00;
        endcase
    endfunction

    function automatic string req_of(input logic [3:0] a);
        case (a)
            4'd1: return "R6";
            4'd2: return "R3";
            4'd3: return "R2";
            4'd4: return "R7";
            4'd5: return "R4";
            4'd6, 4'd7: return "R8|R9";
            4'd8, 4'd9, 4'd10: return "R10";
            4'd14: return "R5";
            default: return "R11";
        endcase
    endfunction

    task automatic m_write(input logic [3:0] a, input logic [7:0] d);
        logic lo = !m_lcr[7];
        logic tg = m_trig();
        case (a)
            4'd1: if (lo) m_ier = m_efr[4] ? d : {m_ier[7:4], d[3:0]};
            4'd2: if (m_lcr == 8'hBF) m_efr = d;
            4'd3: m_lcr = d;
            4'd4: if (lo) m_mcr = m_efr[4] ? d : {m_mcr[7:5], d[4:0]};
            4'd6: if (tg) m_tcr = d;
            4'd7: if (tg) m_tlr = d; else if (lo) m_spr = d;
            4'd8: m_mode = d & 8'h3F;
            4'd9: m_supc = d;
            default: ;
        endcase
    endtask

    task automatic do_write(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        m_write(a, d);
    endtask

    task automatic check_read(input logic [3:0] a, input string req);
        logic [7:0] exp;
        @(negedge clk);
        addr = a; wr_en = 1'b0;
        #1;
        exp = m_read(a);
        total++;
        if (rdata !== exp) begin
            bad++;
            $display("FAIL %s addr=%0d actual=%02h expected=%02h", req, a, rdata, exp);
        end
    endtask

    task automatic read_all();
        for (int a = 0; a < 16; a++) check_read(a[3:0], req_of(a[3:0]));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        m_lcr = 8'h00; m_ier = 8'h00; m_efr = 8'h00; m_mcr = 8'h00;
        m_mode = 8'h07; m_supc = 8'h00; m_tcr = 8'h00; m_tlr = 8'h00; m_spr = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset values seen through each bank
        for (int a = 0; a < 16; a++) check_read(a[3:0], "R1");
        do_write(4'd3, 8'hBF); check_read(4'd2, "R1");
        do_write(4'd3, 8'h80); check_read(4'd14, "R5");
        do_write(4'd3, 8'h00);
        do_write(4'd3, 8'hBF); do_write(4'd2, 8'h10); do_write(4'd3, 8'h00);
        do_write(4'd4, 8'h40);
        check_read(4'd6, "R1"); check_read(4'd7, "R1");

        // directed values from the requirements
        do_write(4'd1, 8'h34); check_read(4'd1, "R6");
        do_write(4'd4, 8'h62); check_read(4'd4, "R7");
        do_write(4'd6, 8'h44); check_read(4'd6, "R8");
        do_write(4'd7, 8'h88); check_read(4'd7, "R8");
        do_write(4'd8, 8'h2E); check_read(4'd8, "R10");
        do_write(4'd8, 8'hFF); check_read(4'd8, "R10");
        do_write(4'd3, 8'hBF); do_write(4'd2, 8'h66); check_read(4'd2, "R3");
        do_write(4'd3, 8'h00);
        check_read(4'd1, "R6"); check_read(4'd6, "R9");
        do_write(4'd1, 8'hFF); check_read(4'd1, "R6");
        do_write(4'd4, 8'hFF); check_read(4'd4, "R7");

        // sweep: bank setups x gate bits x every write address, re-read all
        for (int r = 0; r < 20; r++) begin
            logic [7:0] lcr_sel [5] = '{8'h00, 8'h03, 8'h80, 8'hBF, 8'h45};
            logic e4 = r[0];
            logic m6 = r[1];
            lsr_st  = (r % 3 == 0) ? 8'h01 : (r % 3 == 1) ? 8'h40 : 8'h41;
            msr_st  = 8'h13 * r[7:0];
            iir_st  = 8'hC0 | r[7:0];
            ssr_st  = ~r[7:0];
            uasr_st = 8'h3C ^ r[7:0];
            do_write(4'd3, 8'hBF); do_write(4'd2, {3'b000, e4, 4'h6});
            do_write(4'd3, 8'h00); do_write(4'd4, {1'b0, m6, 6'h05});
            do_write(4'd3, lcr_sel[r / 4]);
            for (int a = 0; a < 16; a++) begin
                logic [7:0] d = 8'hA5 ^ {a[3:0], a[3:0]} ^ r[7:0];
                if (a == 3) d = lcr_sel[(r + 1) % 5];
                do_write(a[3:0], d);
                read_all();
            end
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule